// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block runs the measurement loop of a four-wire resistive touch panel without software involvement. A slow timing strobe paces it through a fixed series of phases. A settle delay comes first, then an X conversion. A second settle delay and a Y conversion follow. After that come a pen-detect wait, a touch-detect wait and an update gap before the loop repeats. Each timed phase lasts a programmable number of strobes. The two conversions go to an external ADC, and the block waits for each result.

At the close of every pen-detect phase the block combines the latest X and Y results and the pen level into one 32-bit word. It pushes that word into a small sample FIFO. Software pops words through a word-addressed register port and can read a status register that carries the empty and overrun flags. An interrupt line goes high when the FIFO holds one word, or four words if the control register selects that. It also goes high while an overrun is pending. The control register also sets the conversion resolution for each axis, and there are four 10-bit coordinate window registers.

Top module: `tsc_scan_top`

## Requirements
- R1: After reset the control register reads 0, the timing registers read settle=2, pen-detect=4, touch-detect=16 and update=88, `irq` is low and `adc_req_valid` is low.
- R2: While scanning, the phases run in this order: settle, X conversion (`adc_req_chan`=0), settle, Y conversion (`adc_req_chan`=1), pen-detect, touch-detect, update, and then back to settle. A timed phase whose register holds N ends on the first cycle in which N strobes of `tick` have been counted within it, so N=0 ends after one cycle. Register word addresses: 0 status, 1 control, 2 FIFO, 3 settle, 4 pen-detect, 5 touch-detect, 6 update.
- R3: In a conversion phase `adc_req_valid` stays high with a stable channel until `adc_req_ready` is sampled high. After that, the first cycle with `adc_res_valid` high captures `adc_res_data` and ends the phase.
- R4: When the pen-detect phase ends with scanning still enabled, the block pushes one word. Bit 31 is `pen_up` as sampled in that cycle (1 means pen up), bits 25:16 hold X, bits 9:0 hold Y, and all other bits are 0.
- R5: Control bits 9:7 (X) and 6:4 (Y) hold 10 minus the resolution in bits. A captured result keeps only its upper (10 - code) bits, and the lower `code` bits are zeroed. Code 0 keeps all 10 bits.
- R6: A read of address 2 returns the oldest word and pops it. Words come out in push order. A read while the FIFO is empty returns 0 and changes nothing.
- R7: A push into a full FIFO is dropped unless a pop happens in the same cycle. A dropped push sets status bit 8, which stays set until the FIFO is empty.
- R8: Status bit 7 is 1 exactly when the FIFO is empty. `irq` is high when bit 8 is set, or when the fill level is at least 4 (control bit 11 = 1) or at least 1 (control bit 11 = 0).
- R9: Scanning runs only while control bit 0 (auto-enable) and bit 2 (ADC power-up) are both 1. If either is cleared, the current phase still finishes, the sequencer then returns to idle, and no further word is pushed.
- R10: Addresses 7 to 10 are the X-min, X-max, Y-min and Y-max windows. Each keeps the low 10 bits of a write and resets to 0x000 for a minimum and 0x3FF for a maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle timing strobe from the slow timebase |
| pen_up | input | 1 | Pen level from the panel detector, 1 = no touch |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at FIFO address) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| irq | output | 1 | FIFO service request |
| adc_req_valid | output | 1 | Conversion request valid |
| adc_req_ready | input | 1 | ADC accepts the request |
| adc_req_chan | output | 1 | Axis to convert, 0 = X, 1 = Y |
| adc_res_valid | input | 1 | Conversion result valid |
| adc_res_data | input | 10 | Conversion result |

## Verification
The assertions assume that the ADC follows the handshake: it returns exactly one result per accepted request and never raises `adc_res_valid` before it has accepted the request. They also assume that `tick` and the register strobes last one cycle each. The bench ADC model accepts requests with a ready pattern that stalls on some cycles, and it returns each result a fixed number of cycles after acceptance, so no stray results appear. The bench drives every register strobe for exactly one cycle. The control register is written at arbitrary points in the scan, so stopping is exercised in different phases.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int ADC_W = 10;
  localparam int REG_AW = 4;
  localparam int DW = 32;

  localparam logic [REG_AW-1:0] A_STAT   = 4'd0;
  localparam logic [REG_AW-1:0] A_CTRL   = 4'd1;
  localparam logic [REG_AW-1:0] A_FIFO   = 4'd2;
  localparam logic [REG_AW-1:0] A_SETTLE = 4'd3;
  localparam logic [REG_AW-1:0] A_PENDET = 4'd4;
  localparam logic [REG_AW-1:0] A_TOUCH  = 4'd5;
  localparam logic [REG_AW-1:0] A_UPDATE = 4'd6;
  localparam logic [REG_AW-1:0] A_XLO    = 4'd7;
  localparam logic [REG_AW-1:0] A_XHI    = 4'd8;
  localparam logic [REG_AW-1:0] A_YLO    = 4'd9;
  localparam logic [REG_AW-1:0] A_YHI    = 4'd10;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETX, PH_CONVX, PH_SETY, PH_CONVY, PH_PEN, PH_TOUCH, PH_UPD
  } phase_e;

  typedef struct packed {
    logic       irq4;
    logic [2:0] xsz;
    logic [2:0] ysz;
    logic       pwr;
    logic       auto_en;
  } ctrl_t;

  function automatic logic [ADC_W-1:0] justify(input logic [ADC_W-1:0] raw,
                                               input logic [2:0] code);
    logic [ADC_W-1:0] keep;
    keep = {ADC_W{1'b1}} << code;
    return raw & keep;
  endfunction
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int TIMW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              fifo_empty,
  input  logic              fifo_ovr,
  input  logic [DW-1:0]     fifo_head,
  output ctrl_t             ctrl,
  output logic [TIMW-1:0]   t_settle,
  output logic [TIMW-1:0]   t_pen,
  output logic [TIMW-1:0]   t_touch,
  output logic [TIMW-1:0]   t_upd,
  output logic [DW-1:0]     rdata
);
  localparam logic [TIMW-1:0] RST_SETTLE = TIMW'(2);
  localparam logic [TIMW-1:0] RST_PEN    = TIMW'(4);
  localparam logic [TIMW-1:0] RST_TOUCH  = TIMW'(16);
  localparam logic [TIMW-1:0] RST_UPD    = TIMW'(88);

  logic [ADC_W-1:0] win_q [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      t_settle <= RST_SETTLE;
      t_pen    <= RST_PEN;
      t_touch  <= RST_TOUCH;
      t_upd    <= RST_UPD;
      win_q[0] <= '0;
      win_q[1] <= '1;
      win_q[2] <= '0;
      win_q[3] <= '1;
    end else if (wr) begin
      case (addr)
        A_CTRL: ctrl <= '{irq4: wdata[11], xsz: wdata[9:7], ysz: wdata[6:4],
                          pwr: wdata[2], auto_en: wdata[0]};
        A_SETTLE: t_settle <= wdata[TIMW-1:0];
        A_PENDET: t_pen    <= wdata[TIMW-1:0];
        A_TOUCH:  t_touch  <= wdata[TIMW-1:0];
        A_UPDATE: t_upd    <= wdata[TIMW-1:0];
        A_XLO:    win_q[0] <= wdata[ADC_W-1:0];
        A_XHI:    win_q[1] <= wdata[ADC_W-1:0];
        A_YLO:    win_q[2] <= wdata[ADC_W-1:0];
        A_YHI:    win_q[3] <= wdata[ADC_W-1:0];
        default: ;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:12], wdata[10], wdata[3], wdata[1]};

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:   rdata = {{(DW-9){1'b0}}, fifo_ovr, fifo_empty, 7'b0};
      A_CTRL:   rdata = {{(DW-12){1'b0}}, ctrl.irq4, 1'b0, ctrl.xsz, ctrl.ysz,
                         1'b0, ctrl.pwr, 1'b0, ctrl.auto_en};
      A_FIFO:   rdata = fifo_head;
      A_SETTLE: rdata = DW'(t_settle);
      A_PENDET: rdata = DW'(t_pen);
      A_TOUCH:  rdata = DW'(t_touch);
      A_UPDATE: rdata = DW'(t_upd);
      A_XLO:    rdata = DW'(win_q[0]);
      A_XHI:    rdata = DW'(win_q[1]);
      A_YLO:    rdata = DW'(win_q[2]);
      A_YHI:    rdata = DW'(win_q[3]);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
  import tsc_pkg::*;
#(
  parameter int TIMW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       xsz,
  input  logic [2:0]       ysz,
  input  logic [TIMW-1:0]  t_settle,
  input  logic [TIMW-1:0]  t_pen,
  input  logic [TIMW-1:0]  t_touch,
  input  logic [TIMW-1:0]  t_upd,
  input  logic             tick,
  input  logic             pen_up,
  output logic             adc_req_valid,
  input  logic             adc_req_ready,
  output logic             adc_req_chan,
  input  logic             adc_res_valid,
  input  logic [ADC_W-1:0] adc_res_data,
  output logic             push,
  output logic [DW-1:0]    push_word
);
  phase_e           phase_q, phase_d;
  logic [TIMW-1:0]  cnt_q, limit;
  logic             sent_q;
  logic [ADC_W-1:0] xv_q, yv_q;
  logic             timed, tdone, is_conv, cdone;

  always_comb begin
    timed = 1'b1;
    case (phase_q)
      PH_SETX, PH_SETY: limit = t_settle;
      PH_PEN:           limit = t_pen;
      PH_TOUCH:         limit = t_touch;
      PH_UPD:           limit = t_upd;
      default: begin
        limit = '0;
        timed = 1'b0;
      end
    endcase
  end

  assign tdone         = timed && (cnt_q >= limit);
  assign is_conv       = (phase_q == PH_CONVX) || (phase_q == PH_CONVY);
  assign cdone         = is_conv && sent_q && adc_res_valid;
  assign adc_req_valid = is_conv && !sent_q;
  assign adc_req_chan  = (phase_q == PH_CONVY);
  assign push          = (phase_q == PH_PEN) && tdone && run;
  assign push_word     = {pen_up, 5'b0, xv_q, 6'b0, yv_q};

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (run)   phase_d = PH_SETX;
      PH_SETX:  if (tdone) phase_d = run ? PH_CONVX : PH_IDLE;
      PH_CONVX: if (cdone) phase_d = run ? PH_SETY  : PH_IDLE;
      PH_SETY:  if (tdone) phase_d = run ? PH_CONVY : PH_IDLE;
      PH_CONVY: if (cdone) phase_d = run ? PH_PEN   : PH_IDLE;
      PH_PEN:   if (tdone) phase_d = run ? PH_TOUCH : PH_IDLE;
      PH_TOUCH: if (tdone) phase_d = run ? PH_UPD   : PH_IDLE;
      PH_UPD:   if (tdone) phase_d = run ? PH_SETX  : PH_IDLE;
      default:             phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sent_q  <= 1'b0;
      xv_q    <= '0;
      yv_q    <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_d != phase_q) begin
        cnt_q  <= '0;
        sent_q <= 1'b0;
      end else begin
        if (timed && tick) cnt_q <= cnt_q + 1'b1;
        if (adc_req_valid && adc_req_ready) sent_q <= 1'b1;
      end
      if (cdone && phase_q == PH_CONVX) xv_q <= justify(adc_res_data, xsz);
      if (cdone && phase_q == PH_CONVY) yv_q <= justify(adc_res_data, ysz);
    end
  end
endmodule

// File: rtl/tsc_fifo.sv
module tsc_fifo
  import tsc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DW-1:0]     push_word,
  input  logic              pop,
  output logic [DW-1:0]     head,
  output logic              empty,
  output logic              ovr,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW   = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wptr, rptr;
  logic            do_pop, accept, drop;

  assign empty  = (fill == '0);
  assign do_pop = pop && !empty;
  assign accept = push && ((fill < FW'(DEPTH)) || do_pop);
  assign drop   = push && !accept;
  assign head   = empty ? '0 : mem[rptr];

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      ovr  <= 1'b0;
    end else begin
      if (accept) wptr <= bump(wptr);
      if (do_pop) rptr <= bump(rptr);
      fill <= fill + FW'(accept) - FW'(do_pop);
      if (drop)       ovr <= 1'b1;
      else if (empty) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/tsc_scan_top.sv
module tsc_scan_top
  import tsc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TIMW      = 10,
  parameter int IRQ_LEVEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pen_up,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              adc_req_valid,
  input  logic              adc_req_ready,
  output logic              adc_req_chan,
  input  logic              adc_res_valid,
  input  logic [ADC_W-1:0]  adc_res_data
);
  localparam int FW = $clog2(DEPTH + 1);

  ctrl_t           ctrl;
  logic [TIMW-1:0] t_settle, t_pen, t_touch, t_upd;
  logic            run_en, push_en, pop_req, fifo_empty, ovr_flag;
  logic [DW-1:0]   push_word, fifo_head;
  logic [FW-1:0]   fill_cnt;

  assign run_en  = ctrl.auto_en && ctrl.pwr;
  assign pop_req = reg_rd && (reg_addr == A_FIFO);
  assign irq     = ovr_flag ||
                   (ctrl.irq4 ? (fill_cnt >= FW'(IRQ_LEVEL)) : !fifo_empty);

  tsc_regs #(.TIMW(TIMW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .fifo_empty(fifo_empty), .fifo_ovr(ovr_flag), .fifo_head(fifo_head),
    .ctrl(ctrl), .t_settle(t_settle), .t_pen(t_pen), .t_touch(t_touch),
    .t_upd(t_upd), .rdata(reg_rdata)
  );

  tsc_seq #(.TIMW(TIMW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run_en), .xsz(ctrl.xsz), .ysz(ctrl.ysz),
    .t_settle(t_settle), .t_pen(t_pen), .t_touch(t_touch), .t_upd(t_upd),
    .tick(tick), .pen_up(pen_up),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready),
    .adc_req_chan(adc_req_chan), .adc_res_valid(adc_res_valid),
    .adc_res_data(adc_res_data), .push(push_en), .push_word(push_word)
  );

  tsc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_en), .push_word(push_word),
    .pop(pop_req), .head(fifo_head), .empty(fifo_empty), .ovr(ovr_flag),
    .fill(fill_cnt)
  );
endmodule

// File: rtl/tsc_scan_chk.sv
module tsc_scan_chk #(
  parameter int DEPTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic adc_req_valid,
  input logic adc_req_ready,
  input logic adc_req_chan,
  input logic irq,
  input logic ovr,
  input logic push,
  input logic pop,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_valid && !adc_req_ready |=> adc_req_valid && $stable(adc_req_chan));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && (fill != 0) |=> ovr);

  // R8
  irq_on_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> irq);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  // R6
  pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && (fill != 0) |=> fill == $past(fill) - 1'b1);
endmodule

bind tsc_scan_top tsc_scan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_req_valid(adc_req_valid),
  .adc_req_ready(adc_req_ready), .adc_req_chan(adc_req_chan), .irq(irq),
  .ovr(ovr_flag), .push(push_en), .pop(pop_req), .fill(fill_cnt)
);

// File: tb/tsc_scan_top_tb.sv
module tsc_scan_top_tb;
  logic clk = 0, rst_n = 0, tick = 0, pen_up = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, adc_req_valid, adc_req_ready = 0, adc_req_chan;
  logic adc_res_valid = 0;
  logic [9:0] adc_res_data = 0;

  always #2 clk = ~clk;

  tsc_scan_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pen_up(pen_up),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready),
    .adc_req_chan(adc_req_chan), .adc_res_valid(adc_res_valid),
    .adc_res_data(adc_res_data)
  );

  int errors = 0, checks = 0, cyc = 0, wd = 0;
  bit finished = 0;

  // behavioural reference state
  int ph, cnt, pend, nres;
  bit sent, m_ovr;
  logic [9:0] m_x, m_y;
  logic [31:0] q[$];
  logic [31:0] m_ctrl;
  int tim[4];
  logic [9:0] win[4];

  function automatic logic [9:0] keep_hi(input logic [9:0] v, input int code);
    logic [9:0] m;
    m = 10'h3FF;
    for (int i = 0; i < code; i++) m[i] = 1'b0;
    return v & m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; pend = -1; nres = 0; sent = 0; m_ovr = 0;
      m_x = 0; m_y = 0; q.delete(); m_ctrl = 0;
      tim[0] = 2; tim[1] = 4; tim[2] = 16; tim[3] = 88;
      win[0] = 0; win[1] = 10'h3FF; win[2] = 0; win[3] = 10'h3FF;
    end else begin
      bit run, timed, tdone, req, cdone, pushit, popit;
      int lim, nph, sz;
      logic [31:0] word;
      run = m_ctrl[0] && m_ctrl[2];
      timed = (ph == 1 || ph == 3 || ph >= 5);
      lim = (ph == 1 || ph == 3) ? tim[0] : (ph == 5) ? tim[1] :
            (ph == 6) ? tim[2] : (ph == 7) ? tim[3] : 0;
      tdone = timed && cnt >= lim;
      req = (ph == 2 || ph == 4) && !sent;
      cdone = (ph == 2 || ph == 4) && sent && adc_res_valid;
      nph = ph; pushit = 0; word = 0;
      case (ph)
        0: if (run) nph = 1;
        1: if (tdone) nph = run ? 2 : 0;
        2: if (cdone) begin m_x = keep_hi(adc_res_data, int'(m_ctrl[9:7])); nph = run ? 3 : 0; end
        3: if (tdone) nph = run ? 4 : 0;
        4: if (cdone) begin m_y = keep_hi(adc_res_data, int'(m_ctrl[6:4])); nph = run ? 5 : 0; end
        5: if (tdone) begin
             if (run) begin pushit = 1; word = {pen_up, 5'b0, m_x, 6'b0, m_y}; end
             nph = run ? 6 : 0;
           end
        6: if (tdone) nph = run ? 7 : 0;
        default: if (tdone) nph = run ? 1 : 0;
      endcase
      if (pend > 0) pend--;
      if (req && adc_req_ready) begin sent = 1; pend = 2; end
      if (cdone) begin pend = -1; nres++; end
      if (nph != ph) begin cnt = 0; sent = 0; end
      else if (timed && tick) cnt++;
      ph = nph;
      sz = q.size();
      popit = reg_rd && reg_addr == 2 && sz > 0;
      if (pushit && !(sz < 8 || popit)) m_ovr = 1;
      else if (sz == 0) m_ovr = 0;
      if (popit) void'(q.pop_front());
      if (pushit && (sz < 8 || popit)) q.push_back(word);
      if (reg_wr) begin
        case (reg_addr)
          1: m_ctrl = reg_wdata & 32'h0000_0BF5;
          3, 4, 5, 6: tim[reg_addr-3] = int'(reg_wdata[9:0]);
          7, 8, 9, 10: win[reg_addr-7] = reg_wdata[9:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0: return {23'b0, m_ovr, (q.size() == 0), 7'b0};
      1: return m_ctrl;
      2: return (q.size() > 0) ? q[0] : 32'h0;
      3, 4, 5, 6: return 32'(tim[a-3]);
      7, 8, 9, 10: return 32'(win[a-7]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic io(input bit wr, input bit rd, input int a, input logic [31:0] d);
    bit exp_req, exp_irq;
    @(negedge clk);
    cyc++;
    reg_wr = wr; reg_rd = rd; reg_addr = 4'(a); reg_wdata = d;
    tick = (cyc % 2 == 0);
    pen_up = ((cyc / 37) % 2) == 1;
    adc_req_ready = (cyc % 3 != 1);
    adc_res_valid = (pend == 0);
    adc_res_data = 10'((nres * 173 + 41) % 1024);
    #1;
    exp_req = (ph == 2 || ph == 4) && !sent;
    check("R2 R3 request", 32'(adc_req_valid), 32'(exp_req));
    if (exp_req) check("R2 channel", 32'(adc_req_chan), 32'(ph == 4));
    exp_irq = m_ovr || (m_ctrl[11] ? q.size() >= 4 : q.size() != 0);
    check("R8 irq", 32'(irq), 32'(exp_irq));
    if (rd) begin
      case (a)
        0: check("R7 R8 status", reg_rdata, exp_rd(a));
        1: check("R1 control", reg_rdata, exp_rd(a));
        2: check("R4 R5 R6 fifo word", reg_rdata, exp_rd(a));
        3, 4, 5, 6: check("R1 R2 timing", reg_rdata, exp_rd(a));
        default: check("R10 window", reg_rdata, exp_rd(a));
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) io(0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 12 && q.size() > 0; i++) io(0, 1, 2, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: got hung expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a <= 10; a++) io(0, 1, a, 0);
    check("R1 reset irq", 32'(irq), 0);
    // R10 window storage
    io(1, 0, 7, 32'h155); io(1, 0, 8, 32'hFFFF);
    io(0, 1, 7, 0); io(0, 1, 8, 0); io(0, 1, 9, 0); io(0, 1, 10, 0);
    // shorter timings, R2
    io(1, 0, 3, 1); io(1, 0, 4, 2); io(1, 0, 5, 0); io(1, 0, 6, 3);
    io(0, 1, 5, 0);
    // main scan, R4
    io(1, 0, 1, 32'h5);
    idle(150); io(0, 1, 0, 0); drain();
    // threshold irq, R8
    io(1, 0, 1, 32'h805);
    idle(80); io(0, 1, 0, 0); drain();
    // overflow, R7
    io(1, 0, 1, 32'h5);
    idle(400); io(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) io(0, 1, 2, 0);
    io(0, 1, 0, 0); drain(); io(0, 1, 0, 0); idle(3); io(0, 1, 0, 0);
    drain(); io(0, 1, 0, 0);
    // resolution codes, R5
    io(1, 0, 1, 32'h5 | (2 << 7) | (5 << 4)); io(0, 1, 1, 0);
    idle(120); drain();
    io(1, 0, 1, 32'h5 | (7 << 7) | (1 << 4));
    idle(60); drain();
    // stop by clearing auto-enable, R9
    io(1, 0, 1, 32'h4);
    idle(200); drain(); idle(100);
    io(0, 1, 0, 0);
    check("R9 no push after stop", 32'(q.size()), 0);
    // power-up cleared while auto set, R9
    io(1, 0, 1, 32'h5); idle(23);
    io(1, 0, 1, 32'h1); idle(200); drain(); idle(100);
    io(0, 1, 0, 0);
    check("R9 powered-down stays idle", 32'(ph), 0);
    // pop on empty, R6
    io(0, 1, 2, 0); io(0, 1, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule